// File: doc/BRIEF.md
# Selectable Fractional Clock Divider

This block turns a decoder reference clock into a low-rate output enable. Its clock input is the reference clock itself, so every rising edge is one reference tick. Software writes a byte-wide configuration word tagged with a packet identifier. Two bits of that word matter here: a demodulator enable and an integer-mode select.

With the enable set and the reference at 160 kHz, integer mode divides by 4, which gives 40 kHz. Fractional mode divides by 25/6, which gives 38.4 kHz. Fractional mode uses a modulo-25 phase accumulator that advances by 6 on every tick. It produces six strobes in every 25 ticks, in the repeating period pattern 4,4,4,4,4,5.

With the enable clear, the reference is assumed to run at 76.8 kHz and feed the decoder directly. The divider stays silent, and the integer-mode select has no effect. The output is a one-tick strobe in the reference domain. A registered square wave is also provided for integer mode. The configuration should be set up before decoding is enabled.

Top module: `fracdiv_clkgen`

## Requirements
- R1: After reset, `mode_en`, `mode_int`, `out_stb` and `out_sq` are all 0.
- R2: The configuration is loaded only on a clock edge where `cfg_wr`=1 and `cfg_id`=1. Bit 0 of `cfg_data` is the demodulator enable and bit 1 is the integer-mode select. The stored values appear on `mode_en`/`mode_int` after that edge. Writes with any other identifier, and bits 7..2, are ignored.
- R3: While `mode_en`=0, `out_stb` and `out_sq` stay 0 whatever the value of `mode_int`.
- R4: With `mode_en`=1 and `mode_int`=1, `out_stb` is high for exactly one cycle every 4 cycles.
- R5: With `mode_en`=1 and `mode_int`=0, `out_stb` pulses six times in every 25 cycles. The gaps between pulses are 4,4,4,4,4,5, repeating.
- R6: In integer mode, `out_sq` is high in the two cycles just before each strobe cycle and low otherwise. In fractional mode `out_sq` is 0.
- R7: A write that changes the enable or the mode restarts the divider. Counting edges after the write edge, the first strobe comes on edge 4 in both modes.
- R8: A write that stores the same two bits again does not disturb the strobe cadence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; each rising edge is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_id | input | 4 | Packet identifier; 1 selects this register |
| cfg_data | input | 8 | Configuration byte: bit 0 enable, bit 1 integer mode |
| mode_en | output | 1 | Stored demodulator enable |
| mode_int | output | 1 | Stored integer-mode select |
| out_stb | output | 1 | One-cycle output strobe |
| out_sq | output | 1 | Square-wave output in integer mode |

## Verification
A wrong divider or accumulator state shows up at `out_stb` within one output period, so no later than 5 ticks. It appears as a strobe one cycle early or late, or as a frame with five or seven pulses. A missed restart shows up as a first strobe that does not land on edge 4 after the mode write. A stored bit that was wrongly captured is visible on `mode_en`/`mode_int` on the very next cycle. The bench compares every cycle against a model that counts ticks since the last restart, so any skew is reported on the cycle where it happens.

// File: rtl/fracdiv_clkgen.sv
module fracdiv_clkgen #(
  parameter int DEN     = 25,
  parameter int NUM     = 6,
  parameter int INT_DIV = 4,
  parameter int ID_W    = 4,
  parameter int DAT_W   = 8,
  parameter int CFG_ID  = 1,
  parameter int EN_BIT  = 0,
  parameter int INT_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [ID_W-1:0]  cfg_id,
  input  logic [DAT_W-1:0] cfg_data,
  output logic             mode_en,
  output logic             mode_int,
  output logic             out_stb,
  output logic             out_sq
);
  localparam int CNT_W = (INT_DIV > 2) ? $clog2(INT_DIV) : 1;
  localparam int ACC_W = $clog2(DEN + NUM);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INT_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(INT_DIV / 2);
  localparam logic [ACC_W-1:0] ACC_NUM  = ACC_W'(NUM);
  localparam logic [ACC_W-1:0] ACC_DEN  = ACC_W'(DEN);
  // preset so the longer period closes each frame: 4,4,4,4,4,5
  localparam logic [ACC_W-1:0] ACC_P0   = ACC_W'(NUM - 1);

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [ACC_W-1:0] acc, acc_sum;
  logic             wr_hit, restart, int_hit, wrap;
  logic             unused_cfg;

  assign wr_hit  = cfg_wr && (cfg_id == ID_W'(CFG_ID));
  assign restart = !mode_en ||
                   (wr_hit && ({cfg_data[EN_BIT], cfg_data[INT_BIT]} != {mode_en, mode_int}));
  assign unused_cfg = ^cfg_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_en  <= 1'b0;
      mode_int <= 1'b0;
    end else if (wr_hit) begin
      mode_en  <= cfg_data[EN_BIT];
      mode_int <= cfg_data[INT_BIT];
    end
  end

  assign int_hit = (cnt == CNT_LAST);
  assign cnt_nxt = int_hit ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (mode_int) cnt <= cnt_nxt;
  end

  assign acc_sum = acc + ACC_NUM;
  assign wrap    = (acc_sum >= ACC_DEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc <= ACC_P0;
    else if (restart)   acc <= ACC_P0;
    else if (!mode_int) acc <= wrap ? acc_sum - ACC_DEN : acc_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_stb <= 1'b0;
      out_sq  <= 1'b0;
    end else if (restart) begin
      out_stb <= 1'b0;
      out_sq  <= 1'b0;
    end else begin
      out_stb <= mode_int ? int_hit : wrap;
      out_sq  <= mode_int && (cnt_nxt >= CNT_HALF);
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_id == ID_W'(CFG_ID)) |=> $stable({mode_en, mode_int})); // R2
  AST_SILENT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |-> !out_stb && !out_sq); // R3
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb |=> !out_stb); // R4
  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    acc < ACC_DEN); // R5
  AST_SQ_INT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_sq |-> mode_en && mode_int); // R6
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && mode_en && cfg_data[INT_BIT] != mode_int) |=> !out_stb && !out_sq); // R7
endmodule

// File: tb/fracdiv_clkgen_bench.sv
module fracdiv_clkgen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_id = 4'd0;
  logic [7:0] cfg_data = 8'd0;
  logic       mode_en, mode_int, out_stb, out_sq;

  int checks = 0;
  int fails  = 0;
  bit m_en = 0, m_int = 0;
  int since = 0;

  always #2.5 clk = ~clk;

  fracdiv_clkgen u_fracdiv_clkgen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_id(cfg_id), .cfg_data(cfg_data),
    .mode_en(mode_en), .mode_int(mode_int), .out_stb(out_stb), .out_sq(out_sq));

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic chk_cycle(string tag);
    logic e_stb, e_sq;
    int p;
    e_stb = 1'b0; e_sq = 1'b0;
    if (m_en && m_int) begin
      e_stb = (since > 0) && (since % 4 == 0);
      e_sq  = (since % 4 == 2) || (since % 4 == 3);
    end else if (m_en) begin
      p = since % 25;
      e_stb = (since > 0) && (p == 0 || p == 4 || p == 8 || p == 12 || p == 16 || p == 20);
    end
    chk({tag, " strobe"}, out_stb, e_stb);
    chk({tag, " square"}, out_sq, e_sq);
    chk({tag, " enable"}, mode_en, m_en);
    chk({tag, " mode"}, mode_int, m_int);
  endtask

  task automatic step(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      since++;
      chk_cycle(tag);
    end
  endtask

  task automatic write_cfg(string tag, logic [3:0] id, logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_id = id; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_id = 4'd0; cfg_data = 8'd0;
    if (id == 4'd1 && (d[0] != m_en || d[1] != m_int)) begin
      m_en = d[0]; m_int = d[1]; since = 0;
    end else begin
      since += 2;
    end
    chk_cycle(tag);
  endtask

  task automatic t_reset;
    chk("R1 stb", out_stb, 1'b0);
    chk("R1 sq", out_sq, 1'b0);
    chk("R1 en", mode_en, 1'b0);
    chk("R1 int", mode_int, 1'b0);
  endtask

  task automatic t_disabled;
    write_cfg("R2 load int-only", 4'd1, 8'h02);
    step("R3 disabled int", 30);
    write_cfg("R2 load zero", 4'd1, 8'h00);
    step("R3 disabled", 10);
  endtask

  task automatic t_integer;
    write_cfg("R7 enter int", 4'd1, 8'h03);
    step("R4 R6 integer", 41);
    write_cfg("R2 foreign id", 4'd2, 8'h00);
    step("R2 after foreign id", 13);
    write_cfg("R8 same value", 4'd1, 8'h03);
    step("R8 after rewrite", 17);
  endtask

  task automatic t_fractional;
    int cnt;
    write_cfg("R7 enter frac", 4'd1, 8'hF1);
    cnt = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      since++;
      chk_cycle("R5 frame");
      if (out_stb) cnt++;
    end
    chk("R5 six per frame", cnt == 6, 1'b1);
    step("R5 fractional", 80);
    write_cfg("R8 same frac", 4'd1, 8'h01);
    step("R8 frac after rewrite", 30);
  endtask

  task automatic t_switch;
    step("R5 pre switch", 7);
    write_cfg("R7 frac to int", 4'd1, 8'h03);
    step("R7 int after switch", 12);
    step("R7 mid", 2);
    write_cfg("R7 int to frac", 4'd1, 8'h01);
    step("R7 frac after switch", 30);
    write_cfg("R3 disable", 4'd1, 8'h00);
    step("R3 silent", 40);
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_disabled;
    t_integer;
    t_fractional;
    t_switch;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule